// File: doc/BRIEF.md
# Cascadable pre-read FIFO

A single-clock FIFO whose read side uses the same one-cycle handshake as its write side. A word enters in a cycle where the active-low write request is low and Full is low. A word leaves in a cycle where the active-low read request is low and Empty is low. No other cycle moves data on either port. A pre-read head register holds the oldest word on the data output whenever Empty is low, so a read needs no separate request cycle.

Both ports have the same timing. One instance's Empty can therefore drive the next instance's write request, and the next instance's Full can drive the first one's read request. A chain built this way moves words forward by itself whenever a stage holds data and its successor has room. Full and Empty come straight from flops, so a chain forms no combinational loop.

Storage is a RAM of `2**ADDR_W` words plus the head register, which gives a capacity of `2**ADDR_W + 1` words. A write into a completely empty FIFO skips the RAM and goes straight to the head register.

Top module: `casc_fifo`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `empty` is 1 and `full` is 0. `full` and `empty` are never high together.
- R2: A write is accepted only in a cycle where `wr_n`=0 and `full`=0. A write attempted while `full`=1 is dropped: it changes neither the contents nor the order of the FIFO.
- R3: A read is accepted only in a cycle where `rd_n`=0 and `empty`=0. A read request while `empty`=1 leaves the FIFO empty and has no effect.
- R4: Whenever `empty`=0, `rd_data` shows the oldest stored word. Words leave in the order they were accepted. Without an accepted read, `rd_data` holds its value.
- R5: After a write is accepted into an empty FIFO, `empty` is 0 on the next cycle and `rd_data` shows that word.
- R6: With `rd_n` held at 0, one word leaves on every clock until the FIFO is empty, with no gap cycles.
- R7: With no reads, `full` rises after exactly `2**ADDR_W + 1` accepted writes.
- R8: When `full`=1 and both `wr_n` and `rd_n` are 0, the read is accepted and the write is refused. `full` is 0 on the next cycle.
- R9: `full` and `empty` change only at a clock edge. `empty` rises only after a cycle with an accepted read, and `full` rises only after a cycle with an accepted write.
- R10: A cycle with both a read and a write accepted leaves the occupancy unchanged.
- R11: Two instances chained with Empty→write request, Full→read request and data out→data in pass every word forward in order, with no other control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write request |
| wr_data | input | DATA_W | Word to write |
| full | output | 1 | Registered: no room for a word |
| rd_n | input | 1 | Active-low read request |
| rd_data | output | DATA_W | Oldest word, valid while `empty` is 0 |
| empty | output | 1 | Registered: no word available |

## Verification
The bench builds the FIFO with `DATA_W`=8 and `ADDR_W`=2: four RAM words plus the head register, so five words in total. With such a small depth, the bench reaches a full FIFO within a few cycles and repeats it many times. It therefore exercises writes against a full FIFO, a read and a write together at the full point, and RAM pointer wrap-around. The same parameters apply to a second pair of chained instances. That chain is driven with random upstream writes and random downstream reads, so back-pressure passes through both stages while a queue model checks both flags and the data on every cycle.

// File: rtl/casc_fifo_pkg.sv
package casc_fifo_pkg;
  // Source feeding the head register in a given cycle
  typedef enum logic [1:0] {
    HEAD_HOLD   = 2'd0,  // keep current word
    HEAD_RAM    = 2'd1,  // load the word at the RAM read pointer
    HEAD_BYPASS = 2'd2,  // load the incoming write word directly
    HEAD_DRAIN  = 2'd3   // head consumed and nothing to replace it
  } head_src_e;
endpackage

// File: rtl/casc_fifo_ram.sv
module casc_fifo_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Asynchronous read lets the head register refill in the same cycle
  assign rdata = mem[raddr];
endmodule

// File: rtl/casc_fifo_ctrl.sv
module casc_fifo_ctrl
  import casc_fifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic              rd_n,
  output logic              full,
  output logic              empty,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [ADDR_W-1:0] ram_raddr,
  output head_src_e         head_src
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0] wptr, rptr, ram_cnt, cnt_nxt;
  logic             head_vld, head_vld_nxt, full_q;
  logic             wr_acc, rd_acc, take, ram_has, ram_re;

  assign wr_acc  = !wr_n && !full_q;
  assign rd_acc  = !rd_n && head_vld;
  assign ram_cnt = wptr - rptr;
  assign ram_has = (ram_cnt != '0);
  assign take    = !head_vld || rd_acc;

  always_comb begin
    if (!take)          head_src = HEAD_HOLD;
    else if (ram_has)   head_src = HEAD_RAM;
    else if (wr_acc)    head_src = HEAD_BYPASS;
    else                head_src = HEAD_DRAIN;
  end

  assign ram_we = wr_acc && (head_src != HEAD_BYPASS);
  assign ram_re = (head_src == HEAD_RAM);

  always_comb begin
    case (head_src)
      HEAD_RAM, HEAD_BYPASS: head_vld_nxt = 1'b1;
      HEAD_DRAIN:            head_vld_nxt = 1'b0;
      default:               head_vld_nxt = head_vld;
    endcase
  end

  assign cnt_nxt = ram_cnt + PTR_W'(ram_we) - PTR_W'(ram_re);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      head_vld <= 1'b0;
      full_q   <= 1'b0;
    end else begin
      if (ram_we) wptr <= wptr + 1'b1;
      if (ram_re) rptr <= rptr + 1'b1;
      head_vld <= head_vld_nxt;
      full_q   <= head_vld_nxt && (cnt_nxt == PTR_W'(DEPTH));
    end
  end

  assign ram_waddr = wptr[ADDR_W-1:0];
  assign ram_raddr = rptr[ADDR_W-1:0];
  assign full      = full_q;
  assign empty     = !head_vld;

  assert_no_ram_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_cnt != PTR_W'(DEPTH)));
  assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  assert_fill_from_empty_R5: assert property (@(posedge clk) disable iff (rst)
    (empty && !wr_n) |=> !empty);
  assert_full_read_frees_R8: assert property (@(posedge clk) disable iff (rst)
    (full && !rd_n) |=> !full);
  assert_refill_no_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && ram_has) |=> !empty);
  assert_empty_after_read_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(empty) |-> $past(rd_acc));
  assert_full_after_write_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> $past(wr_acc));
endmodule

// File: rtl/casc_fifo_head.sv
module casc_fifo_head
  import casc_fifo_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  head_src_e         head_src,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] head_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      head_data <= '0;
    end else begin
      case (head_src)
        HEAD_RAM:    head_data <= ram_rdata;
        HEAD_BYPASS: head_data <= wr_data;
        default:     head_data <= head_data;
      endcase
    end
  end
endmodule

// File: rtl/casc_fifo.sv
module casc_fifo
  import casc_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty
);
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_rdata;
  head_src_e         head_src;

  casc_fifo_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n),
    .full(full), .empty(empty), .ram_we(ram_we),
    .ram_waddr(ram_waddr), .ram_raddr(ram_raddr), .head_src(head_src)
  );

  casc_fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(wr_data),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  casc_fifo_head #(.DATA_W(DATA_W)) head_i (
    .clk(clk), .rst(rst), .head_src(head_src),
    .ram_rdata(ram_rdata), .wr_data(wr_data), .head_data(rd_data)
  );

  assert_head_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (!empty && rd_n) |=> (!empty && $stable(rd_data)));
  assert_read_when_empty_R3: assert property (@(posedge clk) disable iff (rst)
    (empty && wr_n) |=> empty);
endmodule

// File: tb/casc_fifo_tb_top.sv
`timescale 1ns/1ps
module casc_fifo_tb_top;
  localparam int DW  = 8;
  localparam int AW  = 2;
  localparam int CAP = (1 << AW) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          wr_n = 1'b1, rd_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic          full, empty;
  logic [DW-1:0] rd_data;

  casc_fifo #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .wr_n(wr_n), .wr_data(wr_data), .full(full),
    .rd_n(rd_n), .rd_data(rd_data), .empty(empty)
  );

  // Two-stage chain with no glue logic
  logic          a_wr_n = 1'b1, b_rd_n = 1'b1;
  logic [DW-1:0] a_wr_data = '0;
  logic          a_full, a_empty, b_full, b_empty;
  logic [DW-1:0] a_rd_data, b_rd_data;

  casc_fifo #(.DATA_W(DW), .ADDR_W(AW)) chain_a (
    .clk(clk), .rst(rst), .wr_n(a_wr_n), .wr_data(a_wr_data), .full(a_full),
    .rd_n(b_full), .rd_data(a_rd_data), .empty(a_empty)
  );
  casc_fifo #(.DATA_W(DW), .ADDR_W(AW)) chain_b (
    .clk(clk), .rst(rst), .wr_n(a_empty), .wr_data(a_rd_data), .full(b_full),
    .rd_n(b_rd_n), .rd_data(b_rd_data), .empty(b_empty)
  );

  int  q_m[$], qa_m[$], qb_m[$];
  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  string cur_req = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(empty == (q_m.size() == 0), cur_req, "empty", int'(empty), int'(q_m.size() == 0));
    check(full == (q_m.size() == CAP), cur_req, "full", int'(full), int'(q_m.size() == CAP));
    if (q_m.size() > 0)
      check(int'(rd_data) == q_m[0], "R4", "rd_data", int'(rd_data), q_m[0]);
    check(a_empty == (qa_m.size() == 0), "R11", "a_empty", int'(a_empty), int'(qa_m.size() == 0));
    check(a_full == (qa_m.size() == CAP), "R11", "a_full", int'(a_full), int'(qa_m.size() == CAP));
    check(b_empty == (qb_m.size() == 0), "R11", "b_empty", int'(b_empty), int'(qb_m.size() == 0));
    check(b_full == (qb_m.size() == CAP), "R11", "b_full", int'(b_full), int'(qb_m.size() == CAP));
    if (qb_m.size() > 0)
      check(int'(b_rd_data) == qb_m[0], "R11", "b_rd_data", int'(b_rd_data), qb_m[0]);
  endtask

  // Called just after a falling edge: compare, update model, drive inputs
  task automatic step(input logic wn, input logic [DW-1:0] wd, input logic rn);
    logic e0, f0, awn, brn;
    logic [DW-1:0] awd;
    bit wacc, racc, a_w, xfer, b_r;
    int head;
    compare_all();
    e0 = empty; f0 = full;
    wacc = !wn && (q_m.size() < CAP);
    racc = !rn && (q_m.size() > 0);
    if (racc) void'(q_m.pop_front());
    if (wacc) q_m.push_back(int'(wd));
    awn = ($urandom % 3) == 0;
    awd = DW'($urandom);
    brn = ($urandom % 2) == 0;
    a_w  = !awn && (qa_m.size() < CAP);
    xfer = (qa_m.size() > 0) && (qb_m.size() < CAP);
    b_r  = !brn && (qb_m.size() > 0);
    head = (qa_m.size() > 0) ? qa_m[0] : 0;
    if (xfer) void'(qa_m.pop_front());
    if (a_w)  qa_m.push_back(int'(awd));
    if (b_r)  void'(qb_m.pop_front());
    if (xfer) qb_m.push_back(head);
    wr_n = wn; wr_data = wd; rd_n = rn;
    a_wr_n = awn; a_wr_data = awd; b_rd_n = brn;
    #1;
    check(empty == e0, "R9", "empty between edges", int'(empty), int'(e0));
    check(full == f0, "R9", "full between edges", int'(full), int'(f0));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(empty == 1'b1, "R1", "empty in reset", int'(empty), 1);
    check(full == 1'b0, "R1", "full in reset", int'(full), 0);
    rst = 1'b0;
    @(negedge clk);
    check(empty == 1'b1, "R1", "empty after reset", int'(empty), 1);
    check(full == 1'b0, "R1", "full after reset", int'(full), 0);

    cur_req = "R5";
    step(1'b0, 8'hA1, 1'b1);
    step(1'b1, 8'h00, 1'b1);
    step(1'b1, 8'h00, 1'b0);

    cur_req = "R3";
    for (int i = 0; i < 3; i++) step(1'b1, 8'h00, 1'b0);
    step(1'b0, 8'h33, 1'b0);
    step(1'b1, 8'h00, 1'b1);

    cur_req = "R7";
    for (int i = 0; i < CAP - 1; i++) step(1'b0, DW'(8'h40 + i), 1'b1);
    cur_req = "R2";
    for (int i = 0; i < 3; i++) step(1'b0, DW'(8'hE0 + i), 1'b1);

    cur_req = "R8";
    step(1'b0, 8'h77, 1'b0);
    step(1'b1, 8'h00, 1'b1);

    cur_req = "R6";
    for (int i = 0; i < CAP + 2; i++) step(1'b1, 8'h00, 1'b0);

    cur_req = "R10";
    step(1'b0, 8'h11, 1'b1);
    step(1'b0, 8'h12, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, DW'(8'h20 + i), 1'b0);
    for (int i = 0; i < 300; i++)
      step(logic'(($urandom % 3) == 0), DW'($urandom), logic'(($urandom % 2) == 0));
    for (int i = 0; i < 2 * CAP; i++) step(1'b1, 8'h00, 1'b0);
    compare_all();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule